// File: doc/BRIEF.md
# Logarithm range-reduction step (shift-add residual update)

This block performs one step, with index one or higher, of a multiplicative range reduction used to evaluate a logarithm. It takes a small non-negative fixed-point residual Z, known to lie below 2^-P, and a running sum of logarithm terms. It does not multiply by a full reciprocal. Instead it multiplies by 1 - A + E, where A is the leading ALPHA-bit slice of Z and E is a single bit. The result is a new residual that has ALPHA-1 more leading zeros. In the same step a table addressed by A supplies the logarithm of the factor that was applied, and that term is added to the running sum.

All quantities are integers in units of 2^-T_FRAC. With BW = T_FRAC-P_IN-ALPHA, the input residual is ZW = T_FRAC-P_IN bits wide and the output residual is OW = BW+1 bits wide. The parameter SECOND_ITER selects the variant for the first step after the reciprocal stage. In that variant E depends on the top bit of A, which allows ALPHA to equal P_IN. Several instances are chained with growing P_IN to build the full reduction.

Both data paths use valid/ready streams. A word moves on a port in any cycle where valid and ready are both high. The two pipeline registers advance together whenever the output register is empty or is being drained, and `in_ready` shows exactly that condition. While the output is stalled, the block holds every output and accepts nothing.

Top module: `log_rr_stage`

## Requirements
- R1: The input residual z splits into a = z >> BW, which is its ALPHA leading bits at weights 2^-(P_IN+1) down to 2^-(P_IN+ALPHA), and b = z mod 2^BW.
- R2: When SECOND_ITER=0, out_z = b - floor(a*z / 2^(P_IN+ALPHA)) + 2^(T_FRAC-2*P_IN) + floor(z / 2^(2*P_IN)).
- R3: When SECOND_ITER=1 and bit ALPHA-1 of a is 1, the correction is 2^(T_FRAC-2*P_IN) + floor(z / 2^(2*P_IN)). When that bit is 0, the correction is 2^(T_FRAC-2*P_IN-1) + floor(z / 2^(2*P_IN+1)). The rest of the formula is the same as in R2.
- R4: Every new residual satisfies 0 <= out_z < 2^OW, where OW = T_FRAC-P_IN-ALPHA+1. Each step therefore clears ALPHA-1 bits.
- R5: out_sum = (in_sum + L(a)) mod 2^SUM_W. Here L(a) is within one unit of round((E - ln(1 - (a*2^-(P_IN+ALPHA) - E))) * 2^T_FRAC), and E is the correction weight from R2 or R3. L(a) is never negative, including for a = 0.
- R6: With out_ready held high, a word accepted at one rising edge appears on the outputs after the second rising edge that follows. A new word is accepted every cycle.
- R7: While out_valid is high and out_ready is low, out_valid, out_z and out_sum stay unchanged at the next edge. in_ready is high exactly when out_valid is low or out_ready is high.
- R8: During and right after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_z | input | ZW | Residual Z, units of 2^-T_FRAC |
| in_sum | input | SUM_W | Running logarithm sum, units of 2^-T_FRAC |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_z | output | OW | New residual |
| out_sum | output | SUM_W | Updated logarithm sum |

## Verification
Both results, residual and sum, leave through the second register stage. They are therefore due two rising edges after the word was accepted, or later if the output stalls. The bench drives inputs and reads outputs at the falling edge. It pairs each output with its input through an in-order expected queue, so stalls never change which result is compared. The exact two-edge latency is checked only during the opening phase, when out_ready is held high throughout. After that, random stalls exercise the rule that outputs are held stable.

// File: rtl/log_rr_pkg.sv
package log_rr_pkg;

  // Correction weight E, in units of 2^-t.
  function automatic longint corr_units(int t, int p, bit second, bit amsb);
    if (second && !amsb) return longint'(1) <<< (t - 2*p - 1);
    return longint'(1) <<< (t - 2*p);
  endfunction

  // Table entry: E - ln(1 - (A - E)), rounded to units of 2^-t.
  function automatic longint ltab_entry(int a, int p, int al, int t, bit second);
    int     g;
    int     s;
    longint e_s;
    longint x;
    longint pw;
    longint acc;
    longint r;
    g   = 10;
    s   = t + g;
    e_s = corr_units(t, p, second, ((a >> (al-1)) & 1) == 1) <<< g;
    x   = (longint'(a) <<< (s - p - al)) - e_s;
    pw  = x;
    acc = 0;
    for (int k = 1; k <= 12; k++) begin
      acc = acc + pw / k;
      pw  = (pw * x) >>> s;
    end
    r = (acc + e_s + (longint'(1) <<< (g-1))) >>> g;
    if (r < 0) r = 0;
    return r;
  endfunction

endpackage

// File: rtl/rr_digit_mul.sv
module rr_digit_mul #(
  parameter int T_FRAC = 16,
  parameter int P_IN = 5,
  parameter int ALPHA = 4,
  parameter bit SECOND_ITER = 1'b0,
  localparam int ZW = T_FRAC - P_IN,
  localparam int BW = ZW - ALPHA,
  localparam int PW = T_FRAC - 2*P_IN,
  localparam int EW = PW + 1
) (
  input  logic [ZW-1:0]    z,
  output logic [ALPHA-1:0] a,
  output logic [BW-1:0]    b,
  output logic [PW-1:0]    prod,
  output logic [EW-1:0]    eterm
);
  logic [ALPHA+ZW-1:0] full;

  assign a    = z[ZW-1:BW];
  assign b    = z[BW-1:0];
  assign full = a * z;
  assign prod = full[ALPHA+ZW-1:P_IN+ALPHA];

  generate
    if (SECOND_ITER) begin : g_split_corr
      logic amsb;
      assign amsb  = a[ALPHA-1];
      assign eterm = amsb ? (EW'(1) << (T_FRAC-2*P_IN)) + EW'(z >> (2*P_IN))
                          : (EW'(1) << (T_FRAC-2*P_IN-1)) + EW'(z >> (2*P_IN+1));
    end else begin : g_plain_corr
      assign eterm = (EW'(1) << (T_FRAC-2*P_IN)) + EW'(z >> (2*P_IN));
    end
  endgenerate
endmodule

// File: rtl/rr_log_rom.sv
module rr_log_rom #(
  parameter int T_FRAC = 16,
  parameter int P_IN = 5,
  parameter int ALPHA = 4,
  parameter bit SECOND_ITER = 1'b0,
  parameter int LW = 13
) (
  input  logic [ALPHA-1:0] addr,
  output logic [LW-1:0]    val
);
  import log_rr_pkg::*;
  localparam int DEPTH = 2**ALPHA;

  logic [LW-1:0] rom [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      assign rom[g] = LW'(ltab_entry(g, P_IN, ALPHA, T_FRAC, SECOND_ITER));
    end
  endgenerate

  assign val = rom[addr];
endmodule

// File: rtl/rr_residual_join.sv
module rr_residual_join #(
  parameter int BW = 7,
  parameter int PW = 6,
  parameter int EW = 7,
  parameter int FW = 13,
  localparam int OW = BW + 1
) (
  input  logic [BW-1:0]        b,
  input  logic [PW-1:0]        prod,
  input  logic [EW-1:0]        eterm,
  output logic signed [FW-1:0] z_full,
  output logic [OW-1:0]        z_next
);
  assign z_full = $signed({{(FW-BW){1'b0}}, b})
                - $signed({{(FW-PW){1'b0}}, prod})
                + $signed({{(FW-EW){1'b0}}, eterm});
  assign z_next = z_full[OW-1:0];
endmodule

// File: rtl/log_rr_stage.sv
module log_rr_stage #(
  parameter int T_FRAC = 16,
  parameter int P_IN = 5,
  parameter int ALPHA = 4,
  parameter int SUM_W = 20,
  parameter bit SECOND_ITER = 1'b0,
  localparam int ZW = T_FRAC - P_IN,
  localparam int BW = ZW - ALPHA,
  localparam int OW = BW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ZW-1:0]    in_z,
  input  logic [SUM_W-1:0] in_sum,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OW-1:0]    out_z,
  output logic [SUM_W-1:0] out_sum
);
  localparam int PW = T_FRAC - 2*P_IN;
  localparam int EW = PW + 1;
  localparam int LW = T_FRAC - P_IN + 2;
  localparam int FW = ZW + 2;

  logic             en;
  logic [ALPHA-1:0] a_c;
  logic [BW-1:0]    b_c;
  logic [PW-1:0]    prod_c;
  logic [EW-1:0]    eterm_c;
  logic [LW-1:0]    lval_c;

  logic             v1;
  logic [BW-1:0]    b1;
  logic [PW-1:0]    prod1;
  logic [EW-1:0]    eterm1;
  logic [SUM_W-1:0] sum1;

  logic signed [FW-1:0] z_full;
  logic [OW-1:0]        z_next;

  assign en       = !out_valid || out_ready;
  assign in_ready = en;

  rr_digit_mul #(.T_FRAC(T_FRAC), .P_IN(P_IN), .ALPHA(ALPHA), .SECOND_ITER(SECOND_ITER))
    u_mul (.z(in_z), .a(a_c), .b(b_c), .prod(prod_c), .eterm(eterm_c));

  rr_log_rom #(.T_FRAC(T_FRAC), .P_IN(P_IN), .ALPHA(ALPHA), .SECOND_ITER(SECOND_ITER), .LW(LW))
    u_rom (.addr(a_c), .val(lval_c));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      b1     <= '0;
      prod1  <= '0;
      eterm1 <= '0;
      sum1   <= '0;
    end else if (en) begin
      v1     <= in_valid;
      b1     <= b_c;
      prod1  <= prod_c;
      eterm1 <= eterm_c;
      sum1   <= in_sum + SUM_W'(lval_c);
    end
  end

  rr_residual_join #(.BW(BW), .PW(PW), .EW(EW), .FW(FW))
    u_join (.b(b1), .prod(prod1), .eterm(eterm1), .z_full(z_full), .z_next(z_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_z     <= '0;
      out_sum   <= '0;
    end else if (en) begin
      out_valid <= v1;
      out_z     <= z_next;
      out_sum   <= sum1;
    end
  end
endmodule

// File: rtl/log_rr_stage_chk.sv
module log_rr_stage_chk #(
  parameter int OW = 8,
  parameter int FW = 13,
  parameter int SUM_W = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [OW-1:0]        out_z,
  input logic [SUM_W-1:0]     out_sum,
  input logic                 v1,
  input logic signed [FW-1:0] z_full
);
  AST_RESIDUAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |-> (!z_full[FW-1] && (z_full[FW-2:OW] == '0))); // R4

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R7

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_z) && $stable(out_sum))); // R7

  AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 2) && $past(out_ready)) |-> out_valid); // R6

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready)); // R8
endmodule

bind log_rr_stage log_rr_stage_chk #(.OW(OW), .FW(FW), .SUM_W(SUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_z(out_z), .out_sum(out_sum),
  .v1(v1), .z_full(z_full));

// File: tb/tb_log_rr_stage.sv
module tb_log_rr_stage;
  localparam int T = 16;
  localparam int SW = 20;
  localparam int PG = 5, AG = 4;   // general instance
  localparam int PS = 4, AS = 4;   // second-iteration instance
  localparam int ZWG = T-PG, OWG = T-PG-AG+1;
  localparam int ZWS = T-PS, OWS = T-PS-AS+1;
  localparam int NG = 2**ZWG, NS = 2**ZWS;
  localparam int PH1 = 1200;

  logic clk = 1'b0, rst_n = 1'b0, out_ready = 1'b0;
  logic vg = 1'b0, vs = 1'b0;
  logic [ZWG-1:0] zg = '0;
  logic [ZWS-1:0] zs = '0;
  logic [SW-1:0] sg = '0, ss = '0;
  logic rdy_g, rdy_s, ov_g, ov_s;
  logic [OWG-1:0] oz_g;
  logic [OWS-1:0] oz_s;
  logic [SW-1:0] os_g, os_s;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  log_rr_stage #(.T_FRAC(T), .P_IN(PG), .ALPHA(AG), .SUM_W(SW), .SECOND_ITER(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(vg), .in_ready(rdy_g), .in_z(zg), .in_sum(sg),
    .out_valid(ov_g), .out_ready(out_ready), .out_z(oz_g), .out_sum(os_g));

  log_rr_stage #(.T_FRAC(T), .P_IN(PS), .ALPHA(AS), .SUM_W(SW), .SECOND_ITER(1'b1)) dut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(vs), .in_ready(rdy_s), .in_z(zs), .in_sum(ss),
    .out_valid(ov_s), .out_ready(out_ready), .out_z(oz_s), .out_sum(os_s));

  function automatic int ref_z(int z, int p, int al, bit sec);
    int bw, a, b, prod, e;
    bw = T - p - al;
    a = z >> bw;
    b = z % (1 << bw);
    prod = (a * z) / (1 << (p + al));
    if (sec && ((a >> (al-1)) == 0)) e = (1 << (T-2*p-1)) + z / (1 << (2*p+1));
    else e = (1 << (T-2*p)) + z / (1 << (2*p));
    return b - prod + e;
  endfunction

  function automatic int ref_l(int z, int p, int al, bit sec);
    int a;
    real ew, xa, v;
    a = z >> (T - p - al);
    ew = (sec && ((a >> (al-1)) == 0)) ? 2.0**(-(2*p+1)) : 2.0**(-(2*p));
    xa = a * 2.0**(-(p+al));
    v = (ew - $ln(1.0 - (xa - ew))) * 2.0**T;
    return int'($floor(v + 0.5));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int qz_g[NG], ql_g[NG], qi_g[NG], qa_g[NG];
  int qz_s[NS], ql_s[NS], qi_s[NS], qa_s[NS];

  task automatic cmp_sum(int got, int sin, int l, string req);
    int exp, d;
    exp = (sin + l) % (1 << SW);
    d = (got - exp + (1 << SW)) % (1 << SW);
    check(d == 0 || d == 1 || d == (1 << SW) - 1, req, got, exp);
  endtask

  initial begin
    int ig = 0, is = 0, hg = 0, hs = 0;
    bit stall_g = 0, stall_s = 0;
    int hz_g = 0, hsum_g = 0, hz_s = 0, hsum_s = 0;
    repeat (3) @(negedge clk);
    check(ov_g == 1'b0 && ov_s == 1'b0, "R8 out_valid in reset", int'(ov_g), 0);
    check(rdy_g && rdy_s, "R8 in_ready in reset", int'(rdy_g), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ov_g == 1'b0, "R8 out_valid after reset", int'(ov_g), 0);
    check(rdy_g == 1'b1, "R8 in_ready after reset", int'(rdy_g), 1);
    while (hg < NG || hs < NS) begin
      out_ready = (cyc < PH1) ? 1'b1 : ($urandom_range(0, 9) < 6);
      vg = (ig < NG);
      zg = ZWG'(ig);
      sg = SW'(ig * 37);
      vs = (is < NS);
      zs = ZWS'(is);
      ss = SW'(is * 53 + 9);
      #1;
      // R7: held output checks against the previous sample
      if (stall_g) begin
        check(ov_g && int'(oz_g) == hz_g && int'(os_g) == hsum_g, "R7 hold general", int'(oz_g), hz_g);
      end
      if (stall_s) begin
        check(ov_s && int'(oz_s) == hz_s && int'(os_s) == hsum_s, "R7 hold second", int'(oz_s), hz_s);
      end
      check(rdy_g == (!ov_g || out_ready), "R7 ready rule", int'(rdy_g), int'(!ov_g || out_ready));
      stall_g = ov_g && !out_ready;
      stall_s = ov_s && !out_ready;
      hz_g = int'(oz_g); hsum_g = int'(os_g);
      hz_s = int'(oz_s); hsum_s = int'(os_s);
      if (ov_g && out_ready && hg < NG) begin
        // R1 R2 general recurrence, R4 bound, R5 sum
        check(int'(oz_g) == qz_g[hg], "R1 R2 residual", int'(oz_g), qz_g[hg]);
        check(qz_g[hg] >= 0 && qz_g[hg] < (1 << OWG), "R4 bound general", qz_g[hg], 1 << OWG);
        cmp_sum(int'(os_g), (qi_g[hg] * 37) % (1 << SW), ql_g[hg], "R5 sum general");
        if (cyc < PH1) check(cyc - qa_g[hg] == 2, "R6 latency", cyc - qa_g[hg], 2);
        hg++;
      end
      if (ov_s && out_ready && hs < NS) begin
        // R1 R3 split correction, R4 bound, R5 sum
        check(int'(oz_s) == qz_s[hs], "R1 R3 residual", int'(oz_s), qz_s[hs]);
        check(qz_s[hs] >= 0 && qz_s[hs] < (1 << OWS), "R4 bound second", qz_s[hs], 1 << OWS);
        cmp_sum(int'(os_s), (qi_s[hs] * 53 + 9) % (1 << SW), ql_s[hs], "R5 sum second");
        if (cyc < PH1) check(cyc - qa_s[hs] == 2, "R6 latency second", cyc - qa_s[hs], 2);
        hs++;
      end
      if (vg && rdy_g) begin
        qz_g[ig] = ref_z(ig, PG, AG, 1'b0);
        ql_g[ig] = ref_l(ig, PG, AG, 1'b0);
        qi_g[ig] = ig; qa_g[ig] = cyc; ig++;
      end
      if (vs && rdy_s) begin
        qz_s[is] = ref_z(is, PS, AS, 1'b1);
        ql_s[is] = ref_l(is, PS, AS, 1'b1);
        qi_s[is] = is; qa_s[is] = cyc; is++;
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule